// File: doc/BRIEF.md
# Serial Transceiver with Loop and Single-Wire Routing

This block is an asynchronous serial transmitter and receiver joined by a routing stage. The routing stage picks one of three paths for the receiver. In normal mode the receiver listens on its own receive pin. In loop mode the transmitter's pin value is fed back inside the block and the receive pin is ignored. In single-wire mode the receiver listens on the transmit pin, and the transmitter drives that pin only while it sends a frame. The transmit side and the receive side each have their own polarity inversion.

Bytes go in through a valid/ready write handshake. A received byte is held with a valid flag until software acknowledges it. A wait-request input, qualified by a stop-in-wait control, freezes the baud timing. The transmitter and receiver then hold their exact position in the frame and carry on where they stopped once the wait ends. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The receiver oversamples each bit sixteen times.

Top module: `uart_loop_route`

## Requirements
- R1: With tx_en high and no frame in progress, tx_ready is high. A byte accepted by tx_valid&tx_ready leaves on txd_out as one low start bit, eight data bits LSB first and one high stop bit, each bit 16*CLK_DIV clocks long. tx_ready stays low until the frame is over.
- R2: With loop_sel low, a well-formed frame arriving on rxd_in sets rx_valid and places the byte on rx_data. rx_valid stays high until a one-cycle pulse on rx_ack clears it.
- R3: A frame whose stop bit is sampled low sets rx_frame_err and does not set rx_valid. rx_ack clears rx_frame_err.
- R4: With loop_sel=1 and src_sel=0 (loop mode), the value driven on txd_out is routed inside the block to the receiver. Activity on rxd_in changes neither rx_valid, rx_frame_err nor rx_data.
- R5: Reception needs rx_en high, so in loop mode with rx_en low a transmitted byte sets no rx_valid. With tx_en low, tx_ready is low and txd_out rests at its idle level.
- R6: With loop_sel=1 and src_sel=1 (single-wire mode), the receiver listens on txd_in. txd_oe is high only while a frame is being sent and low otherwise. In every other mode txd_oe is high.
- R7: With tx_inv high, txd_out carries the inverted frame and idles low. With tx_inv low, txd_out idles high.
- R8: With rx_inv high, the receiver inverts the routed line before it decodes it. In loop mode, equal tx_inv and rx_inv give correct bytes. Unequal values give rx_frame_err and no rx_valid.
- R9: While wait_req and stop_in_wait are both high, the baud timing stops and txd_out and the frame position are held. When the wait ends the frame finishes intact, and tx_en and rx_en need not be applied again. With stop_in_wait low, wait_req has no effect.
- R10: Each received bit is the majority of oversamples 7, 8 and 9. A glitch one oversample wide in the middle of a bit does not change the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| loop_sel | input | 1 | 1 selects an internal route (loop or single-wire) |
| src_sel | input | 1 | With loop_sel=1: 0 loop, 1 single-wire |
| tx_inv | input | 1 | Invert the transmit pin |
| rx_inv | input | 1 | Invert the receiver's input line |
| stop_in_wait | input | 1 | Allow wait_req to freeze the baud timing |
| wait_req | input | 1 | Wait-mode request |
| tx_data | input | DW | Byte to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter accepts a byte |
| rx_data | output | DW | Last correctly received byte |
| rx_valid | output | 1 | rx_data holds an unacknowledged byte |
| rx_frame_err | output | 1 | A frame ended with a low stop bit |
| rx_ack | input | 1 | Clears rx_valid and rx_frame_err |
| rxd_in | input | 1 | Receive pin |
| txd_in | input | 1 | Sensed level of the transmit pin |
| txd_out | output | 1 | Transmit pin drive value |
| txd_oe | output | 1 | Transmit pin drive enable |

## Verification
Two functions that can act at the same moment are the loop return path and the external receive pin. In the bench, a byte is transmitted in loop mode while a different frame is driven onto rxd_in at the same time. The result passes only if the byte received is the one transmitted and no framing error appears. A second overlap puts a wait freeze in the middle of a transmitted frame. The bench checks that txd_out stays unchanged for hundreds of cycles, and then decodes the whole frame, counting only the cycles that were not frozen.

// File: rtl/uart_lr_pkg.sv
package uart_lr_pkg;

  typedef enum logic [1:0] {
    RT_NORMAL = 2'd0,
    RT_LOOP   = 2'd1,
    RT_SINGLE = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic route_e pick_route(input logic loop_sel, input logic src_sel);
    if (!loop_sel)    return RT_NORMAL;
    else if (src_sel) return RT_SINGLE;
    else              return RT_LOOP;
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_lr_baud.sv
module uart_lr_baud #(
  parameter int CLK_DIV = 27
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (!freeze) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_lr_tx.sv
module uart_lr_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          freeze,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic          line,
  output logic          busy
);
  localparam int FW = DW + 2;
  localparam int SW = $clog2(OVS);
  localparam int BW = $clog2(FW + 1);
  localparam logic [SW-1:0] S_LAST = SW'(OVS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(FW - 1);

  logic [FW-1:0] sh;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitcnt;

  assign wr_ready = en & ~busy & ~freeze;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '1;
      sub    <= '0;
      bitcnt <= '0;
      busy   <= 1'b0;
      line   <= 1'b1;
    end else if (!en) begin
      busy <= 1'b0;
      line <= 1'b1;
    end else if (!busy) begin
      if (wr_valid && wr_ready) begin
        sh     <= {1'b1, wr_data, 1'b0};
        sub    <= '0;
        bitcnt <= '0;
        busy   <= 1'b1;
        line   <= 1'b0;
      end
    end else if (tick) begin
      if (sub == S_LAST) begin
        sub <= '0;
        if (bitcnt == B_LAST) begin
          busy <= 1'b0;
          line <= 1'b1;
        end else begin
          bitcnt <= bitcnt + BW'(1);
          sh     <= {1'b1, sh[FW-1:1]};
          line   <= sh[1];
        end
      end else begin
        sub <= sub + SW'(1);
      end
    end
  end
endmodule

// File: rtl/uart_lr_rx.sv
module uart_lr_rx
  import uart_lr_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          line,
  input  logic          ack,
  output logic [DW-1:0] data,
  output logic          valid,
  output logic          ferr
);
  localparam int SW = $clog2(OVS);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [SW-1:0] S_A    = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] S_B    = SW'(OVS / 2);
  localparam logic [SW-1:0] S_C    = SW'(OVS / 2 + 1);
  localparam logic [SW-1:0] S_LAST = SW'(OVS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DW - 1);

  rx_state_e     st;
  logic          prev;
  logic          sa, sb, vote;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] sh;

  assign vote = maj3(sa, sb, line);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RX_HUNT;
      prev   <= 1'b0;
      sa     <= 1'b0;
      sb     <= 1'b0;
      sub    <= '0;
      bitcnt <= '0;
      sh     <= '0;
      data   <= '0;
      valid  <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      if (ack) begin
        valid <= 1'b0;
        ferr  <= 1'b0;
      end
      if (!en) begin
        st   <= RX_HUNT;
        prev <= 1'b0;
      end else if (tick) begin
        prev <= line;
        if (st == RX_HUNT) begin
          if (prev && !line) begin
            st  <= RX_START;
            sub <= SW'(1);
          end
        end else begin
          if (sub == S_A) sa <= line;
          if (sub == S_B) sb <= line;
          if (sub == S_C) begin
            case (st)
              RX_START: if (vote) st <= RX_HUNT;
              RX_DATA:  sh <= {vote, sh[DW-1:1]};
              RX_STOP: begin
                if (vote) begin
                  data  <= sh;
                  valid <= 1'b1;
                end else begin
                  ferr <= 1'b1;
                end
                st <= RX_HUNT;
              end
              default: ;
            endcase
          end
          if (sub == S_LAST) begin
            sub <= '0;
            if (st == RX_START) begin
              st     <= RX_DATA;
              bitcnt <= '0;
            end else if (st == RX_DATA) begin
              if (bitcnt == B_LAST) st <= RX_STOP;
              else                  bitcnt <= bitcnt + BW'(1);
            end
          end else begin
            sub <= sub + SW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_lr_route.sv
module uart_lr_route
  import uart_lr_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic loop_sel,
  input  logic src_sel,
  input  logic tx_inv,
  input  logic rx_inv,
  input  logic tx_line,
  input  logic tx_busy,
  input  logic rxd_pin,
  input  logic txd_pin_in,
  output logic txd_out,
  output logic txd_oe,
  output logic rx_line
);
  logic [SYNC-1:0] rxd_sh;
  logic [SYNC-1:0] pin_sh;
  logic            src_bit;
  route_e          mode;

  assign mode = pick_route(loop_sel, src_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_sh  <= '1;
      pin_sh  <= '1;
      txd_out <= 1'b1;
      txd_oe  <= 1'b1;
    end else begin
      rxd_sh  <= {rxd_sh[SYNC-2:0], rxd_pin};
      pin_sh  <= {pin_sh[SYNC-2:0], txd_pin_in};
      txd_out <= tx_line ^ tx_inv;
      txd_oe  <= (mode != RT_SINGLE) | tx_busy;
    end
  end

  always_comb begin
    case (mode)
      RT_LOOP:   src_bit = txd_out;
      RT_SINGLE: src_bit = pin_sh[SYNC-1];
      default:   src_bit = rxd_sh[SYNC-1];
    endcase
    rx_line = src_bit ^ rx_inv;
  end
endmodule

// File: rtl/uart_loop_route.sv
module uart_loop_route #(
  parameter int DW      = 8,
  parameter int OVS     = 16,
  parameter int CLK_DIV = 27,
  parameter int SYNC    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          loop_sel,
  input  logic          src_sel,
  input  logic          tx_inv,
  input  logic          rx_inv,
  input  logic          stop_in_wait,
  input  logic          wait_req,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_frame_err,
  input  logic          rx_ack,
  input  logic          rxd_in,
  input  logic          txd_in,
  output logic          txd_out,
  output logic          txd_oe
);
  logic freeze;
  logic tick;
  logic tx_line;
  logic tx_busy;
  logic rx_line;

  assign freeze = wait_req & stop_in_wait;

  uart_lr_baud #(.CLK_DIV(CLK_DIV)) u_baud (
    .clk(clk), .rst(rst), .freeze(freeze), .tick(tick)
  );

  uart_lr_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .en(tx_en), .freeze(freeze),
    .wr_data(tx_data), .wr_valid(tx_valid), .wr_ready(tx_ready),
    .line(tx_line), .busy(tx_busy)
  );

  uart_lr_route #(.SYNC(SYNC)) u_route (
    .clk(clk), .rst(rst), .loop_sel(loop_sel), .src_sel(src_sel),
    .tx_inv(tx_inv), .rx_inv(rx_inv), .tx_line(tx_line), .tx_busy(tx_busy),
    .rxd_pin(rxd_in), .txd_pin_in(txd_in),
    .txd_out(txd_out), .txd_oe(txd_oe), .rx_line(rx_line)
  );

  uart_lr_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(rx_en), .line(rx_line),
    .ack(rx_ack), .data(rx_data), .valid(rx_valid), .ferr(rx_frame_err)
  );
endmodule

// File: rtl/uart_loop_route_chk.sv
module uart_loop_route_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic rx_en,
  input logic loop_sel,
  input logic src_sel,
  input logic tx_inv,
  input logic stop_in_wait,
  input logic wait_req,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_frame_err,
  input logic txd_out,
  input logic txd_oe
);
  AST_OE_OUTSIDE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !(loop_sel && src_sel) |=> txd_oe); // R6

  AST_VALID_NEEDS_RX_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> $past(rx_en)); // R5

  AST_ERR_NOT_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    !($rose(rx_valid) && $rose(rx_frame_err))); // R3

  AST_TX_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tx_ready)) |-> (txd_out == !$past(tx_inv))); // R7

  AST_FREEZE_HOLDS_TXD: assert property (@(posedge clk) disable iff (rst)
    (wait_req && stop_in_wait && $past(wait_req && stop_in_wait) && tx_en)
      |=> (!$stable(tx_inv) || !tx_en || $stable(txd_out))); // R9
endmodule

bind uart_loop_route uart_loop_route_chk u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
  .loop_sel(loop_sel), .src_sel(src_sel), .tx_inv(tx_inv),
  .stop_in_wait(stop_in_wait), .wait_req(wait_req), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
  .txd_out(txd_out), .txd_oe(txd_oe)
);

// File: tb/uart_loop_route_tb.sv
module uart_loop_route_tb;
  localparam int DW = 8;
  localparam int OVS = 16;
  localparam int DIV = 2;
  localparam int BITC = OVS * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b1, rx_en = 1'b1, loop_sel = 1'b0, src_sel = 1'b0;
  logic tx_inv = 1'b0, rx_inv = 1'b0, stop_in_wait = 1'b0, wait_req = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ack = 1'b0;
  logic tx_ready, rx_valid, rx_frame_err, txd_out, txd_oe;
  logic [DW-1:0] rx_data;
  logic rxd_v = 1'b1, remote_v = 1'b1, remote_en = 1'b0;
  logic txd_in;
  logic frz;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  assign txd_in = txd_oe ? txd_out : (remote_en ? remote_v : ~tx_inv);
  assign frz = wait_req & stop_in_wait;

  uart_loop_route #(.DW(DW), .OVS(OVS), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
    .loop_sel(loop_sel), .src_sel(src_sel), .tx_inv(tx_inv), .rx_inv(rx_inv),
    .stop_in_wait(stop_in_wait), .wait_req(wait_req),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_ack(rx_ack), .rxd_in(rxd_v), .txd_in(txd_in),
    .txd_out(txd_out), .txd_oe(txd_oe)
  );

  // {src_sel, tx_inv, rx_inv, data, expect_valid, expect_err}; loop_sel = 1
  localparam logic [12:0] VECS [8] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'h55, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 8'hF0, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 8'h81, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b1, 8'h6E, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [DW-1:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic ack_rx();
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
  endtask

  task automatic set_line(input int tgt, input logic v);
    if (tgt == 0) rxd_v = v;
    else          remote_v = v;
  endtask

  // glitch_bit: frame bit index (0 = start) that gets a one-oversample pulse in its middle
  task automatic drive_frame(input int tgt, input logic [DW-1:0] b, input logic stopv, input int glitch_bit);
    logic [9:0] f;
    f = {stopv, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < BITC; c++) begin
        if (i == glitch_bit && (c == BITC / 2 - 1 || c == BITC / 2)) set_line(tgt, ~f[i]);
        else set_line(tgt, f[i]);
        @(negedge clk);
      end
    end
    set_line(tgt, 1'b1);
  endtask

  task automatic decode_tx(input logic inv, output logic [DW-1:0] b, output logic stop_ok);
    logic [9:0] f;
    int cnt;
    while (txd_out !== inv) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      while (cnt < BITC / 2 + BITC * i) begin
        @(negedge clk);
        if (!frz) cnt++;
      end
      f[i] = txd_out ^ inv;
    end
    b = f[8:1];
    stop_ok = f[9] & ~f[0];
  endtask

  initial begin
    #(5.0 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    logic sok;
    logic ref_v;
    int unstable;

    clks(5);
    rst = 1'b0;
    clks(3);
    // Reset state
    chk(txd_out == 1'b1, "R7 reset idle", txd_out, 1);
    chk(txd_oe == 1'b1, "R6 reset oe", txd_oe, 1);
    chk(rx_valid == 1'b0 && rx_frame_err == 1'b0, "R2 reset flags", {rx_valid, rx_frame_err}, 0);
    chk(tx_ready == 1'b1, "R1 reset ready", tx_ready, 1);

    // R1 normal transmit
    fork
      send_byte(8'h4B);
      decode_tx(1'b0, got, sok);
      begin clks(10); chk(tx_ready == 1'b0, "R1 busy ready", tx_ready, 0); end
    join
    chk(got == 8'h4B, "R1 tx byte", got, 8'h4B);
    chk(sok == 1'b1, "R1 tx framing", sok, 1);
    clks(BITC);
    chk(tx_ready == 1'b1, "R1 ready after", tx_ready, 1);

    // R2 normal receive
    drive_frame(0, 8'hA5, 1'b1, -1);
    clks(10);
    chk(rx_valid == 1'b1, "R2 rx valid", rx_valid, 1);
    chk(rx_data == 8'hA5, "R2 rx data", rx_data, 8'hA5);
    ack_rx();
    clks(2);
    chk(rx_valid == 1'b0, "R2 ack clears", rx_valid, 0);

    // R3 framing error
    drive_frame(0, 8'h33, 1'b0, -1);
    clks(BITC);
    chk(rx_frame_err == 1'b1, "R3 err set", rx_frame_err, 1);
    chk(rx_valid == 1'b0, "R3 no valid", rx_valid, 0);
    ack_rx();
    clks(2);
    chk(rx_frame_err == 1'b0, "R3 ack clears", rx_frame_err, 0);

    // R10 single-oversample glitch in data bit 3
    drive_frame(0, 8'h5A, 1'b1, 4);
    clks(10);
    chk(rx_valid == 1'b1 && rx_data == 8'h5A, "R10 glitch rejected", rx_data, 8'h5A);
    ack_rx();

    // R7 inverted transmit
    tx_inv = 1'b1;
    clks(4);
    chk(txd_out == 1'b0, "R7 idle low", txd_out, 0);
    fork
      send_byte(8'hD2);
      decode_tx(1'b1, got, sok);
    join
    chk(got == 8'hD2 && sok, "R7 inverted frame", got, 8'hD2);
    clks(BITC);
    tx_inv = 1'b0;
    clks(4);

    // R9 freeze in mid frame
    stop_in_wait = 1'b1;
    unstable = 0;
    fork
      begin send_byte(8'hC3); decode_tx(1'b0, got, sok); end
      begin
        clks(100);
        wait_req = 1'b1;
        clks(4);
        ref_v = txd_out;
        for (int k = 0; k < 300; k++) begin
          @(negedge clk);
          if (txd_out !== ref_v) unstable++;
        end
        wait_req = 1'b0;
      end
    join
    chk(unstable == 0, "R9 txd held", unstable, 0);
    chk(got == 8'hC3 && sok, "R9 frame resumes", got, 8'hC3);
    clks(BITC);
    // R9 wait without stop_in_wait has no effect
    stop_in_wait = 1'b0;
    wait_req = 1'b1;
    fork
      send_byte(8'h69);
      decode_tx(1'b0, got, sok);
    join
    chk(got == 8'h69 && sok, "R9 runs in wait", got, 8'h69);
    wait_req = 1'b0;
    clks(BITC);

    // R4 loop ignores rxd_in
    loop_sel = 1'b1;
    src_sel  = 1'b0;
    clks(20);
    ack_rx();
    drive_frame(0, 8'h77, 1'b1, -1);
    clks(BITC);
    chk(rx_valid == 1'b0 && rx_frame_err == 1'b0, "R4 rxd ignored", {rx_valid, rx_frame_err}, 0);
    fork
      send_byte(8'h1E);
      drive_frame(0, 8'h00, 1'b0, -1);
    join
    clks(BITC * 2);
    chk(rx_valid == 1'b1 && rx_data == 8'h1E, "R4 loop data", rx_data, 8'h1E);
    chk(rx_frame_err == 1'b0, "R4 no err", rx_frame_err, 0);
    ack_rx();

    // R5 enables
    rx_en = 1'b0;
    send_byte(8'h42);
    clks(BITC * 12);
    chk(rx_valid == 1'b0, "R5 rx disabled", rx_valid, 0);
    rx_en = 1'b1;
    tx_en = 1'b0;
    clks(4);
    chk(tx_ready == 1'b0 && txd_out == 1'b1, "R5 tx disabled", {tx_ready, txd_out}, 1);
    tx_en = 1'b1;
    clks(4);

    // R6 single-wire
    src_sel = 1'b1;
    clks(BITC);
    ack_rx();
    chk(txd_oe == 1'b0, "R6 released idle", txd_oe, 0);
    remote_en = 1'b1;
    drive_frame(1, 8'h96, 1'b1, -1);
    remote_en = 1'b0;
    clks(10);
    chk(rx_valid == 1'b1 && rx_data == 8'h96, "R6 remote data", rx_data, 8'h96);
    ack_rx();
    fork
      send_byte(8'h2D);
      begin clks(50); chk(txd_oe == 1'b1, "R6 driven in frame", txd_oe, 1); end
    join
    clks(BITC * 12);
    chk(txd_oe == 1'b0, "R6 released after", txd_oe, 0);
    chk(rx_valid == 1'b1 && rx_data == 8'h2D, "R6 own echo", rx_data, 8'h2D);

    // Vector table: loop and single-wire with polarity combinations (R4, R6, R8)
    foreach (VECS[i]) begin
      string tag;
      logic [12:0] v;
      v = VECS[i];
      tag = v[12] ? "R6 table" : ((v[11] != v[10]) ? "R8 mismatch" : (v[11] ? "R8 matched" : "R4 table"));
      loop_sel = 1'b1;
      src_sel  = v[12];
      tx_inv   = v[11];
      rx_inv   = v[10];
      clks(800);
      ack_rx();
      clks(4);
      send_byte(v[9:2]);
      clks(800);
      chk(rx_valid == v[1], tag, rx_valid, v[1]);
      if (v[1]) chk(rx_data == v[9:2], tag, rx_data, v[9:2]);
      chk(rx_frame_err == v[0], tag, rx_frame_err, v[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule